// File: doc/BRIEF.md
# Scan Test Vector Sequencer

This block sits on the tester side of one multiplexed-D scan chain. After a start pulse it runs a complete scan test on the design it is wired to. The design under test has `NS` scan flip-flops, a test-control input, a serial scan-in, a serial scan-out and a set of primary inputs and outputs.

The run has two parts. First comes a chain-integrity shift of `NS + 4` clocks. Then come `NC` combinational test vectors. For each vector the sequencer shifts a present state into the chain and applies one capture clock with the primary inputs for that vector. While the next state shifts in, it unloads the captured response. All expected values are elaboration parameters. The first mismatch is latched, together with the vector it belongs to and the clock on which it was seen.

The block has no streaming interface. `start`, `busy`, `done` and the fail status are plain level or pulse signals. A run cannot be stalled or back-pressured: it always takes the same number of clocks.

Top module: `scan_vector_seq`

## Requirements
- R1: After reset `busy`, `done`, `fail` and `scan_tc` are 0. When `start` is high at a clock edge while `busy` is 0, a run begins at that edge and `done` and `fail` are cleared. When `start` is high while `busy` is 1, it is ignored.
- R2: The first `NS + 4` clocks of a run hold `scan_tc` at 1. On run clock t, `scan_si` carries bit 1 of t, which gives the sequence 0,0,1,1,0,0,1,1,…
- R3: During the chain-integrity clocks, `scan_so` is compared only on clocks t ≥ `NS`, against the value driven on `scan_si` on clock t − `NS`.
- R4: Each vector k begins with `NS` clocks at `scan_tc` = 1. On its j-th clock (j from 0) the sequencer drives bit `NS-1-j` of field k of `PRESENT_ST`. Field k occupies bits [k·NS +: NS], and bit i of a field is flop i, counted from the scan-in end.
- R5: After the `NS` shift clocks of vector k comes exactly one clock with `scan_tc` = 0. On that clock `dut_pi` equals field k of `APPLY_PI` ([k·PI_W +: PI_W]) and `dut_po` is compared with field k of `EXPECT_PO`.
- R6: On the j-th shift clock of vector k ≥ 1, `scan_so` is compared with bit `NS-1-j` of field k−1 of `EXPECT_NS`. On the `NS` unload clocks after the last capture, `scan_so` is compared with the same bit of field `NC-1`.
- R7: `scan_so` is not compared during the shift clocks of vector 0, and it is never compared on capture clocks.
- R8: `scan_si` is 0 on capture and unload clocks. `dut_pi` is 0 on every clock that is not a capture clock, and while idle.
- R9: `done` rises exactly (NS+4) + (NS+1)·NC + NS clocks after the starting edge. `busy` falls at that same edge.
- R10: The first mismatch sets `fail`. `fail_cyc` takes the run clock index, counted from 0. `fail_vec` takes the vector index, or the value `NC` for a chain-integrity mismatch. Later mismatches change none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the design under test |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| scan_tc | output | 1 | Test control: 1 shifts the chain, 0 captures |
| scan_si | output | 1 | Serial data into the chain |
| dut_pi | output | PI_W | Primary inputs applied to the design |
| dut_po | input | PO_W | Primary outputs of the design |
| scan_so | input | 1 | Serial data out of the chain |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished; held until the next start |
| fail | output | 1 | At least one mismatch in the last run |
| fail_vec | output | $clog2(NC+1) | Vector index of the first mismatch |
| fail_cyc | output | $clog2(TOTAL+1) | Run clock index of the first mismatch |

## Verification
On every shift clock of vector k ≥ 1, two things happen in the same cycle: the present state of vector k goes out on `scan_si`, and the response of vector k−1 is judged on `scan_so`. The bench provokes this by flipping the scan-out bit on a randomly chosen shift clock of a later vector, and on an unload clock. On every clock it checks that the scan-in stream still matches the vector k pattern. When the run ends, it requires that the failure is charged to vector k−1 at that exact clock. Flips placed on clocks that must not be judged (the early chain-test clocks, vector 0 shifts, capture clocks) must leave the run passing.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    PH_CHAIN  = 2'd0,
    PH_SHIFT  = 2'd1,
    PH_CAPT   = 2'd2,
    PH_UNLOAD = 2'd3
  } phase_e;
endpackage

// File: rtl/scan_seq_timer.sv
module scan_seq_timer
  import scan_seq_pkg::*;
#(
  parameter int NS = 3,
  parameter int NC = 4,
  localparam int TOTAL = (NS + 4) + (NS + 1) * NC + NS,
  localparam int CW = $clog2(TOTAL + 1),
  localparam int VW = $clog2(NC + 1),
  localparam int SW = $clog2(NS + 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output phase_e        phase,
  output logic [SW-1:0] sub,
  output logic [VW-1:0] vec,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= PH_CHAIN;
      sub   <= '0;
      vec   <= '0;
      cnt   <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      phase <= PH_CHAIN;
      sub   <= '0;
      vec   <= '0;
      cnt   <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      case (phase)
        PH_CHAIN: begin
          if (sub == SW'(NS + 3)) begin
            phase <= PH_SHIFT;
            sub   <= '0;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        PH_SHIFT: begin
          if (sub == SW'(NS - 1)) begin
            phase <= PH_CAPT;
            sub   <= '0;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        PH_CAPT: begin
          sub <= '0;
          if (vec == VW'(NC - 1)) begin
            phase <= PH_UNLOAD;
          end else begin
            phase <= PH_SHIFT;
            vec   <= vec + 1'b1;
          end
        end
        default: begin
          if (sub == SW'(NS - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
      endcase
    end
  end

  // R9: phase sequencing and the plain clock counter agree on the run length
  p_run_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cnt) == CW'(TOTAL - 1));
  // R1: a start seen mid-run does not restart the counter
  p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt != CW'(TOTAL - 1)) |=> (cnt == $past(cnt) + 1'b1));
  // R5: a capture never lasts more than one clock
  p_single_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == PH_CAPT) |=> (phase != PH_CAPT));
endmodule

// File: rtl/scan_seq_driver.sv
module scan_seq_driver
  import scan_seq_pkg::*;
#(
  parameter int NS = 3,
  parameter int NC = 4,
  parameter int PI_W = 3,
  parameter logic [NC*NS-1:0]   PRESENT_ST = '0,
  parameter logic [NC*PI_W-1:0] APPLY_PI   = '0,
  localparam int VW = $clog2(NC + 1),
  localparam int SW = $clog2(NS + 4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  phase_e          phase,
  input  logic [SW-1:0]   sub,
  input  logic [VW-1:0]   vec,
  output logic            tc,
  output logic            si,
  output logic [PI_W-1:0] pi
);
  always_comb begin
    tc = 1'b0;
    si = 1'b0;
    pi = '0;
    if (busy) begin
      case (phase)
        PH_CHAIN: begin
          tc = 1'b1;
          si = sub[1];
        end
        PH_SHIFT: begin
          tc = 1'b1;
          si = PRESENT_ST[int'(vec) * NS + NS - 1 - int'(sub)];
        end
        PH_CAPT: begin
          pi = APPLY_PI[int'(vec) * PI_W +: PI_W];
        end
        default: begin
          tc = 1'b1;
        end
      endcase
    end
  end

  // R8: the serial line carries filler while the chain captures
  p_capture_filler_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tc) |-> !si);
endmodule

// File: rtl/scan_seq_judge.sv
module scan_seq_judge
  import scan_seq_pkg::*;
#(
  parameter int NS = 3,
  parameter int NC = 4,
  parameter int PO_W = 2,
  parameter logic [NC*PO_W-1:0] EXPECT_PO = '0,
  parameter logic [NC*NS-1:0]   EXPECT_NS = '0,
  localparam int TOTAL = (NS + 4) + (NS + 1) * NC + NS,
  localparam int CW = $clog2(TOTAL + 1),
  localparam int VW = $clog2(NC + 1),
  localparam int SW = $clog2(NS + 4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            busy,
  input  phase_e          phase,
  input  logic [SW-1:0]   sub,
  input  logic [VW-1:0]   vec,
  input  logic [CW-1:0]   cnt,
  input  logic            so,
  input  logic [PO_W-1:0] po,
  output logic            fail,
  output logic [VW-1:0]   fail_vec,
  output logic [CW-1:0]   fail_cyc
);
  logic          mism;
  logic [VW-1:0] mvec;
  int            back;

  always_comb begin
    mism = 1'b0;
    mvec = vec;
    back = int'(sub) - NS;
    if (busy) begin
      case (phase)
        PH_CHAIN: begin
          mvec = VW'(NC);
          if (back >= 0) mism = (so != back[1]);
        end
        PH_SHIFT: begin
          mvec = vec - 1'b1;
          if (vec != '0)
            mism = (so != EXPECT_NS[(int'(vec) - 1) * NS + NS - 1 - int'(sub)]);
        end
        PH_CAPT: begin
          mism = (po != EXPECT_PO[int'(vec) * PO_W +: PO_W]);
        end
        default: begin
          mvec = VW'(NC - 1);
          mism = (so != EXPECT_NS[(NC - 1) * NS + NS - 1 - int'(sub)]);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail     <= 1'b0;
      fail_vec <= '0;
      fail_cyc <= '0;
    end else if (start && !busy) begin
      fail     <= 1'b0;
      fail_vec <= '0;
      fail_cyc <= '0;
    end else if (mism && !fail) begin
      fail     <= 1'b1;
      fail_vec <= mvec;
      fail_cyc <= cnt;
    end
  end

  // R10: the first mismatch record is never overwritten within a run
  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && busy) |=> (fail && $stable(fail_vec) && $stable(fail_cyc)));
  // R10: the reported index is a vector number or the chain-test code
  p_fail_vec_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (int'(fail_vec) <= NC));
endmodule

// File: rtl/scan_vector_seq.sv
module scan_vector_seq
  import scan_seq_pkg::*;
#(
  parameter int NS = 3,
  parameter int NC = 4,
  parameter int PI_W = 3,
  parameter int PO_W = 2,
  parameter logic [NC*NS-1:0]   PRESENT_ST = 12'h5A3,
  parameter logic [NC*PI_W-1:0] APPLY_PI   = 12'h1C6,
  parameter logic [NC*PO_W-1:0] EXPECT_PO  = 8'h9B,
  parameter logic [NC*NS-1:0]   EXPECT_NS  = 12'h3E4,
  localparam int TOTAL = (NS + 4) + (NS + 1) * NC + NS,
  localparam int CW = $clog2(TOTAL + 1),
  localparam int VW = $clog2(NC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            scan_tc,
  output logic            scan_si,
  output logic [PI_W-1:0] dut_pi,
  input  logic [PO_W-1:0] dut_po,
  input  logic            scan_so,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [VW-1:0]   fail_vec,
  output logic [CW-1:0]   fail_cyc
);
  localparam int SW = $clog2(NS + 4);

  phase_e        phase;
  logic [SW-1:0] sub;
  logic [VW-1:0] vec;
  logic [CW-1:0] cnt;

  scan_seq_timer #(.NS(NS), .NC(NC)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .phase(phase), .sub(sub), .vec(vec), .cnt(cnt)
  );

  scan_seq_driver #(.NS(NS), .NC(NC), .PI_W(PI_W),
                    .PRESENT_ST(PRESENT_ST), .APPLY_PI(APPLY_PI)) i_driver (
    .clk(clk), .rst_n(rst_n), .busy(busy), .phase(phase), .sub(sub), .vec(vec),
    .tc(scan_tc), .si(scan_si), .pi(dut_pi)
  );

  scan_seq_judge #(.NS(NS), .NC(NC), .PO_W(PO_W),
                   .EXPECT_PO(EXPECT_PO), .EXPECT_NS(EXPECT_NS)) i_judge (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .phase(phase),
    .sub(sub), .vec(vec), .cnt(cnt), .so(scan_so), .po(dut_po),
    .fail(fail), .fail_vec(fail_vec), .fail_cyc(fail_cyc)
  );

  // R8: idle leaves the design in functional mode with quiet inputs
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scan_tc && dut_pi == '0 && !scan_si));
  // R9: done and busy are never high together
  p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
endmodule

// File: tb/test_scan_vector_seq.sv
module test_scan_vector_seq;
  localparam int TB_NS = 3;
  localparam int TB_NC = 5;
  localparam int TB_PIW = 3;
  localparam int TB_POW = 2;
  localparam int TOT = (TB_NS + 4) + (TB_NS + 1) * TB_NC + TB_NS;
  localparam int CW = $clog2(TOT + 1);
  localparam int VW = $clog2(TB_NC + 1);

  function automatic logic [2:0] f_nxt(logic [2:0] s, logic [2:0] p);
    return {s[1:0], s[2]} ^ p ^ {2'b00, s[2] & p[0]};
  endfunction
  function automatic logic [1:0] f_po(logic [2:0] s, logic [2:0] p);
    return {^(s & p), s[0] | p[2]};
  endfunction
  function automatic logic [TB_NC*3-1:0] gen3(logic [31:0] seed);
    logic [31:0] x;
    logic [TB_NC*3-1:0] r;
    x = seed;
    r = '0;
    for (int k = 0; k < TB_NC; k++) begin
      x = x * 32'd1103515245 + 32'd12345;
      r[k*3 +: 3] = x[18:16];
    end
    return r;
  endfunction
  function automatic logic [TB_NC*3-1:0] gen_ns(logic [TB_NC*3-1:0] st, logic [TB_NC*3-1:0] pv);
    logic [TB_NC*3-1:0] r;
    for (int k = 0; k < TB_NC; k++) r[k*3 +: 3] = f_nxt(st[k*3 +: 3], pv[k*3 +: 3]);
    return r;
  endfunction
  function automatic logic [TB_NC*2-1:0] gen_po(logic [TB_NC*3-1:0] st, logic [TB_NC*3-1:0] pv);
    logic [TB_NC*2-1:0] r;
    for (int k = 0; k < TB_NC; k++) r[k*2 +: 2] = f_po(st[k*3 +: 3], pv[k*3 +: 3]);
    return r;
  endfunction

  localparam logic [TB_NC*3-1:0] ST  = gen3(32'h0000_1234);
  localparam logic [TB_NC*3-1:0] PIV = gen3(32'h0000_9E37);
  localparam logic [TB_NC*3-1:0] XNS = gen_ns(ST, PIV);
  localparam logic [TB_NC*2-1:0] XPO = gen_po(ST, PIV);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, flip_so, flip_po;
  logic scan_tc, scan_si, scan_so, busy, done, fail;
  logic [TB_PIW-1:0] dut_pi;
  logic [TB_POW-1:0] dut_po;
  logic [VW-1:0] fail_vec;
  logic [CW-1:0] fail_cyc;
  logic [2:0] dq;

  always_ff @(posedge clk) begin
    if (scan_tc) dq <= {dq[1:0], scan_si};
    else         dq <= f_nxt(dq, dut_pi);
  end
  assign scan_so = dq[2] ^ flip_so;
  assign dut_po  = f_po(dq, dut_pi) ^ {1'b0, flip_po};

  scan_vector_seq #(.NS(TB_NS), .NC(TB_NC), .PI_W(TB_PIW), .PO_W(TB_POW),
    .PRESENT_ST(ST), .APPLY_PI(PIV), .EXPECT_PO(XPO), .EXPECT_NS(XNS)) i_scan_vector_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_tc(scan_tc), .scan_si(scan_si),
    .dut_pi(dut_pi), .dut_po(dut_po), .scan_so(scan_so), .busy(busy), .done(done),
    .fail(fail), .fail_vec(fail_vec), .fail_cyc(fail_cyc)
  );

  int n_chk = 0;
  int n_bad = 0;
  int wd = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 200000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  // phase of run clock t: 0 chain, 1 shift, 2 capture, 3 unload
  function automatic int ph(int t);
    int u;
    if (t < TB_NS + 4) return 0;
    u = t - (TB_NS + 4);
    if (u >= (TB_NS + 1) * TB_NC) return 3;
    return (u % (TB_NS + 1) == TB_NS) ? 2 : 1;
  endfunction
  function automatic int kk(int t);
    return (t - (TB_NS + 4)) / (TB_NS + 1);
  endfunction
  function automatic int jj(int t);
    if (ph(t) == 3) return t - (TB_NS + 4) - (TB_NS + 1) * TB_NC;
    return (t - (TB_NS + 4)) % (TB_NS + 1);
  endfunction
  function automatic logic [4:0] exp_drive(int t);
    logic tc, si;
    logic [2:0] p;
    tc = 1'b1; si = 1'b0; p = 3'b000;
    case (ph(t))
      0: si = t[1];
      1: si = ST[kk(t)*3 + 2 - jj(t)];
      2: begin tc = 1'b0; p = PIV[kk(t)*3 +: 3]; end
      default: ;
    endcase
    return {tc, si, p};
  endfunction
  function automatic string req_of(int t);
    case (ph(t))
      0: return "R2";
      1: return "R4";
      2: return "R5";
      default: return "R8";
    endcase
  endfunction
  function automatic bit so_judged(int t);
    case (ph(t))
      0: return t >= TB_NS;
      1: return kk(t) >= 1;
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction
  function automatic int vec_of(int t);
    case (ph(t))
      0: return TB_NC;
      1: return kk(t) - 1;
      2: return kk(t);
      default: return TB_NC - 1;
    endcase
  endfunction

  task automatic run(int so_t, int po_t, bit mid_start, string req);
    bit efail;
    int evec, ecyc;
    efail = 1'b0; evec = 0; ecyc = 0;
    for (int t = 0; t < TOT; t++) begin
      if (!efail && ((t == so_t && so_judged(t)) || (t == po_t && ph(t) == 2))) begin
        efail = 1'b1; evec = vec_of(t); ecyc = t;
      end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && !done && !fail, "R1", "run start clears done/fail", {busy, done, fail}, 3'b100);
    for (int t = 0; t < TOT; t++) begin
      flip_so = (t == so_t);
      flip_po = (t == po_t);
      start   = mid_start && (t == 10);
      check({scan_tc, scan_si, dut_pi} == exp_drive(t), req_of(t), "tc/si/pi drive",
            int'({scan_tc, scan_si, dut_pi}), int'(exp_drive(t)));
      if (t == TOT - 1) check(!done && busy, "R9", "done early", int'(done), 0);
      @(negedge clk);
    end
    flip_so = 1'b0; flip_po = 1'b0; start = 1'b0;
    check(done && !busy, "R9", "done after run length", int'({done, busy}), 2);
    check(fail == efail, req, "fail flag", int'(fail), int'(efail));
    if (efail) begin
      check(int'(fail_vec) == evec, req, "fail vector", int'(fail_vec), evec);
      check(int'(fail_cyc) == ecyc, "R10", "fail clock", int'(fail_cyc), ecyc);
    end
    @(negedge clk);
    check(!scan_tc && dut_pi == '0, "R8", "idle drive", int'({scan_tc, dut_pi}), 0);
  endtask

  initial begin
    int k, j;
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; flip_so = 1'b0; flip_po = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!busy && !done && !fail && !scan_tc, "R1", "reset state",
          int'({busy, done, fail, scan_tc}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // clean run with a start pulse in the middle (R1, R9)
    run(-1, -1, 1'b1, "R1");
    // chain-test mismatch first, later capture mismatch must not overwrite (R3, R10)
    run(TB_NS + 1, TB_NS + 4 + 2 * (TB_NS + 1) + TB_NS, 1'b0, "R3");
    // early chain-test clock is not judged (R3)
    run(2, -1, 1'b0, "R3");
    // vector 0 shift is not judged (R7)
    run(TB_NS + 4 + 1, -1, 1'b0, "R7");
    // capture clock does not judge scan-out (R7)
    run(TB_NS + 4 + 3 * (TB_NS + 1) + TB_NS, -1, 1'b0, "R7");
    // random overlap clocks: response of k-1 judged while k shifts in (R6)
    for (int r = 0; r < 4; r++) begin
      k = 1 + int'($urandom_range(TB_NC - 2));
      j = int'($urandom_range(TB_NS - 1));
      run(TB_NS + 4 + k * (TB_NS + 1) + j, -1, 1'b0, "R6");
    end
    // unload clock (R6)
    j = int'($urandom_range(TB_NS - 1));
    run(TB_NS + 4 + TB_NC * (TB_NS + 1) + j, -1, 1'b0, "R6");
    // random capture output mismatches (R5)
    for (int r = 0; r < 3; r++) begin
      k = int'($urandom_range(TB_NC - 1));
      run(-1, TB_NS + 4 + k * (TB_NS + 1) + TB_NS, 1'b0, "R5");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule